// File: doc/BRIEF.md
# Staggered Sense-Line Pulse Scheduler

This block sits between the memory read path and the open-drain drivers that pull the host's sense lines. When the read sequencer signals that a word is valid, the block captures the 18-bit word (16 data bits and 2 parity bits). It then releases per-bit driver enables a few bits at a time. Only a bounded number of lines switch in any one clock, which caps the current drawn through the cable at any instant.

The number of bits released per clock is the parameter `GROUP`. It must divide the word width evenly and must be at least 2. With the default of 3, the word goes out over six consecutive cycles. With a value of 2, it goes out over nine. Releasing one bit per clock would make the transfer too long for the host's read window, so that setting is rejected at elaboration. An enable is raised only for a bit that holds 1, so a 0 bit never drives its sense line.

Top module: `sense_stagger`

## Requirements
- R1: While reset is asserted (active-low `rst_n`) and after it is released with no start, every `sense_en` bit and `done` are 0.
- R2: A `sense_en` bit is 1 only if the matching bit of the word captured at the accepted start is 1.
- R3: In no cycle are more than `GROUP` bits of `sense_en` high.
- R4: A start is sampled on a rising clock edge while the block is idle. Counting that edge as edge 0, slot k covers bits k*GROUP through k*GROUP+GROUP-1, in ascending order. Slot k is presented for exactly the one cycle after edge k, for k = 0 to WIDTH/GROUP-1.
- R5: `done` is high for exactly one cycle, the cycle after edge WIDTH/GROUP, and is low at every other time.
- R6: A start that arrives while a sequence is running is ignored. Changes on `word` after the accepted start do not alter the enables of that sequence.
- R7: `GROUP` sets the schedule length. The default 3 gives 6 slots and 2 gives 9 slots. A `GROUP` below 2, or one that does not divide `WIDTH`, stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Word-valid strobe from the read sequencer |
| word | input | WIDTH | Word read from memory, parity in the top two bits |
| sense_en | output | WIDTH | Per-bit sense driver enables |
| done | output | 1 | One-cycle pulse after the last slot |

## Verification
The bench runs two copies of the block side by side, one with three bits per slot and one with two. For each copy it computes, cycle by cycle, which bits must be lit. Stimulus includes all-zero and all-one words, alternating patterns, every walking one and walking zero, and a set of pseudo-random words.

A scheduler whose slot counter skipped or repeated a slot would light a group in the wrong cycle or light it twice. Missing masking would light 0 bits. A premature or late `done` would be caught on the exact cycle. To test R6, the bench re-strobes start partway through and scrambles the input word right after capture. A design that restarted, or that read the live input, would show enables that no longer match the captured word.

// File: rtl/sense_stagger.sv
module sense_stagger #(
  parameter int WIDTH = 18,
  parameter int GROUP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] sense_en,
  output logic             done
);
  localparam int NSLOT = WIDTH / GROUP;
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  generate
    if (GROUP < 2 || (WIDTH % GROUP) != 0) begin : g_bad_group
      $error("sense_stagger: GROUP must be >= 2 and divide WIDTH");
    end
  endgenerate

  logic             busy;
  logic [SW-1:0]    slot;
  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= '0;
      word_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          slot   <= '0;
          word_q <= word;
        end
      end else if (slot == LAST) begin
        busy <= 1'b0;
        slot <= '0;
        done <= 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam logic [SW-1:0] MYSLOT = SW'(i / GROUP);
      assign sense_en[i] = busy && (slot == MYSLOT) && word_q[i];
    end
  endgenerate

  p_group_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sense_en) <= GROUP);

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot != LAST) |=> (busy && slot == $past(slot) + 1'b1));

  p_last_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot == LAST) |=> (done && !busy));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && slot != LAST) |=> (busy && $stable(word_q)));

  p_quiet_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sense_en == '0));
endmodule

// File: tb/sim_sense_stagger.sv
module sim_sense_stagger;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] word = '0;
  logic [W-1:0] en0, en1;
  logic done0, done1;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sense_stagger #(.WIDTH(W), .GROUP(3)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word),
    .sense_en(en0), .done(done0));

  sense_stagger #(.WIDTH(W), .GROUP(2)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word),
    .sense_en(en1), .done(done1));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %05h expected %05h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] expect_en(input logic [W-1:0] w, input int g, input int c);
    logic [W-1:0] e = '0;
    for (int i = 0; i < W; i++)
      if (c < W / g && i / g == c) e[i] = w[i];
    return e;
  endfunction

  task automatic sample(input logic [W-1:0] w, input int c);
    chk("R4/R2 g3 enables", en0, expect_en(w, 3, c));
    chk("R4/R7 g2 enables", en1, expect_en(w, 2, c));
    chk("R5 g3 done", W'(done0), W'(c == 6));
    chk("R5/R7 g2 done", W'(done1), W'(c == 9));
    chk("R3 g3 cap", W'($countones(en0) <= 3), W'(1));
    chk("R2 g2 only ones", en1 & ~w, '0);
  endtask

  task automatic run_word(input logic [W-1:0] w, input bit poke);
    @(negedge clk);
    word = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    word = ~w;
    for (int c = 0; c <= 10; c++) begin
      sample(w, c);
      start = poke && (c == 2 || c == 4);
      word = poke ? (~w ^ W'(c * 37)) : ~w;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R1 reset en g3", en0, '0);
    chk("R1 reset done", W'({done0, done1}), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle en g2", en1, '0);
    chk("R1 idle done", W'({done0, done1}), '0);
    run_word('0, 1'b0);
    run_word('1, 1'b0);
    run_word(18'h15555, 1'b1);
    run_word(18'h2AAAA, 1'b0);
    for (int i = 0; i < W; i++) run_word(W'(1) << i, 1'b0);
    for (int i = 0; i < W; i++) run_word(~(W'(1) << i), i[0]);
    lfsr = 18'h2B4C1;
    for (int n = 0; n < 24; n++) begin
      lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
      run_word(lfsr, n[0]);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule